// File: doc/BRIEF.md
# Shared GPIO / Serial-Clock Pin Controller

This block manages a single bidirectional port pin that serves two users. One is ordinary software-driven I/O. The other is the clock line of a small synchronous serial unit. The CPU sees three one-bit registers: a direction bit, an output data latch and a pulldown-inhibit bit. It writes them over a minimal register bus and reads them back over the same bus. The serial unit supplies an enable, a master-select and its outgoing clock.

While the serial unit is enabled, it owns the pad. In master mode the pad drives the serial clock out. In slave mode the pad is an input, and its level is handed unsynchronized to the serial unit as its clock. The pulldown is off whenever the serial unit owns the pin. The CPU registers stay fully accessible during that time, but they do not affect the pad. When the serial enable drops, the stored register values take control again in the same cycle.

Reads of the data address return the pad level when the direction bit is clear, and the stored latch when it is set. The pad level first passes through a two-flop synchronizer.

Top module: `gpio_sclk_pin`

## Requirements
- R1: After reset all three register bits read 0, the pad output-enable is 0, the pulldown-enable is 1 and the pad output value is 0.
- R2: With serial enable 1 and master 1, the output-enable is 1 and the pad output follows the serial unit's outgoing clock.
- R3: With serial enable 1 and master 0, the output-enable is 0 and the serial clock input equals the pad level combinationally. In every other mode the serial clock input is 0.
- R4: While serial enable is 1, the pulldown-enable is 0 regardless of the pulldown-inhibit bit.
- R5: While serial enable is 1, CPU writes to the direction, data and inhibit bits are stored and read back, and they change none of the pad outputs.
- R6: With the direction bit at 0, a read of the data address returns the pad level delayed by two clock edges through a synchronizer. This also holds while the serial unit owns the pin.
- R7: With the direction bit at 1, a read of the data address returns the stored data latch.
- R8: With serial enable 0 and the direction bit at 0, the output-enable is 0 and the pulldown-enable is the inverse of the inhibit bit.
- R9: With serial enable 0 and the direction bit at 1, the output-enable is 1, the pad output equals the data bit and the pulldown-enable is 0. The master input is ignored in this mode.
- R10: In the cycle in which serial enable falls, the pad outputs follow the register values that are stored at that moment.
- R11: The register map is address 0 = direction, 1 = data, 2 = pulldown inhibit, 3 = reserved. A register captures bit 0 of the write data on the clock edge of a write. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 1 | Register write data |
| bus_rdata | output | 1 | Register read data (combinational on address) |
| ser_en | input | 1 | Serial unit enable |
| ser_master | input | 1 | Serial unit master select |
| ser_clk_out | input | 1 | Clock produced by the serial unit |
| ser_clk_in | output | 1 | Pad clock handed to the serial unit in slave mode |
| pad_in | input | 1 | Level sensed at the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad output-buffer enable |
| pad_pd_en | output | 1 | Pad pulldown enable |

## Verification
The assertions check the ownership rules on every cycle: master drive, slave pass-through and the quiet clock input, the pulldown being off under serial ownership, the plain input and output modes, and the two-edge synchronizer delay on the read path.

Some behaviour can only be shown by the bench's scenarios. These are:
- the reset values;
- writes made during serial ownership leaving the pad untouched and later being read back;
- the handover on serial release;
- the reserved address being inert.

// File: rtl/gpio_sclk_pkg.sv
package gpio_sclk_pkg;
  typedef enum logic [1:0] {
    REG_DIR   = 2'd0,
    REG_DATA  = 2'd1,
    REG_PDINH = 2'd2,
    REG_RSVD  = 2'd3
  } reg_sel_e;

  // Output-buffer enable: serial owner picks by master bit, else direction bit
  function automatic logic drive_en(logic se, logic ms, logic dir);
    return se ? ms : dir;
  endfunction

  // Value presented to the pad buffer
  function automatic logic pad_value(logic se, logic ms, logic sclk, logic data);
    return (se && ms) ? sclk : data;
  endfunction

  // Pulldown only for a CPU-owned input without inhibit
  function automatic logic pull_en(logic se, logic dir, logic inh);
    return !se && !dir && !inh;
  endfunction

  // Slave clock handed to the serial unit
  function automatic logic slave_clk(logic se, logic ms, logic pin);
    return se && !ms && pin;
  endfunction
endpackage

// File: rtl/gpio_sclk_regs.sv
module gpio_sclk_regs
  import gpio_sclk_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata,
  input  logic              pin_sync,
  output logic              rdata,
  output logic              dir_q,
  output logic              data_q,
  output logic              inh_q
);
  logic sel_dir, sel_data, sel_inh;

  assign sel_dir  = (addr == ADDR_W'(REG_DIR));
  assign sel_data = (addr == ADDR_W'(REG_DATA));
  assign sel_inh  = (addr == ADDR_W'(REG_PDINH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      data_q <= 1'b0;
      inh_q  <= 1'b0;
    end else if (wr) begin
      if (sel_dir)  dir_q  <= wdata;
      if (sel_data) data_q <= wdata;
      if (sel_inh)  inh_q  <= wdata;
    end
  end

  always_comb begin
    rdata = 1'b0;
    if (sel_dir)  rdata = dir_q;
    if (sel_data) rdata = dir_q ? data_q : pin_sync;
    if (sel_inh)  rdata = inh_q;
  end
endmodule

// File: rtl/gpio_sclk_sync.sv
module gpio_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_sclk_mux.sv
module gpio_sclk_mux
  import gpio_sclk_pkg::*;
(
  input  logic ser_en,
  input  logic ser_master,
  input  logic ser_clk_out,
  input  logic pad_in,
  input  logic dir_q,
  input  logic data_q,
  input  logic inh_q,
  output logic pad_out,
  output logic pad_oe,
  output logic pad_pd_en,
  output logic ser_clk_in
);
  assign pad_oe     = drive_en(ser_en, ser_master, dir_q);
  assign pad_out    = pad_value(ser_en, ser_master, ser_clk_out, data_q);
  assign pad_pd_en  = pull_en(ser_en, dir_q, inh_q);
  assign ser_clk_in = slave_clk(ser_en, ser_master, pad_in);
endmodule

// File: rtl/gpio_sclk_pin.sv
module gpio_sclk_pin #(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wdata,
  output logic              bus_rdata,
  input  logic              ser_en,
  input  logic              ser_master,
  input  logic              ser_clk_out,
  output logic              ser_clk_in,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pad_pd_en
);
  // Named internal events for the bound checker
  logic dir_q, data_q, inh_q, pin_sync, ser_owns;

  assign ser_owns = ser_en;

  gpio_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_sclk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .pin_sync(pin_sync), .rdata(bus_rdata),
    .dir_q(dir_q), .data_q(data_q), .inh_q(inh_q)
  );

  gpio_sclk_mux u_mux (
    .ser_en(ser_en), .ser_master(ser_master), .ser_clk_out(ser_clk_out),
    .pad_in(pad_in), .dir_q(dir_q), .data_q(data_q), .inh_q(inh_q),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd_en(pad_pd_en),
    .ser_clk_in(ser_clk_in)
  );
endmodule

// File: rtl/gpio_sclk_pin_chk.sv
module gpio_sclk_pin_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       bus_wdata,
  input logic       bus_rdata,
  input logic       ser_en,
  input logic       ser_master,
  input logic       ser_clk_out,
  input logic       ser_clk_in,
  input logic       pad_in,
  input logic       pad_out,
  input logic       pad_oe,
  input logic       pad_pd_en,
  input logic       ser_owns,
  input logic       dir_q,
  input logic       data_q,
  input logic       inh_q,
  input logic       pin_sync
);
  // Cycles since reset, saturating, so $past never reaches into reset
  logic [1:0] since_rst;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;

  assign settled = (since_rst >= 2'd2);

  assert_master_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && ser_master) |-> (pad_oe && pad_out == ser_clk_out));

  assert_slave_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && !ser_master) |-> (!pad_oe && ser_clk_in == pad_in));

  assert_clkin_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_en && !ser_master) |-> !ser_clk_in);

  assert_pull_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_owns |-> !pad_pd_en);

  assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (pin_sync == $past(pad_in, 2)));

  assert_read_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_q && bus_addr == 2'd1) |-> (bus_rdata == pin_sync));

  assert_read_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q && bus_addr == 2'd1) |-> (bus_rdata == data_q));

  assert_input_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en && !dir_q) |-> (!pad_oe && pad_pd_en == !inh_q));

  assert_output_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en && dir_q) |-> (pad_oe && pad_out == data_q && !pad_pd_en));

  assert_data_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && $past(bus_wr && bus_addr == 2'd1)) |-> (data_q == $past(bus_wdata)));

  assert_rsvd_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> !bus_rdata);
endmodule

bind gpio_sclk_pin gpio_sclk_pin_chk u_chk (.*);

// File: tb/gpio_sclk_pin_tb.sv
module gpio_sclk_pin_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wdata = 1'b0;
  logic       bus_rdata;
  logic       ser_en = 1'b0, ser_master = 1'b0, ser_clk_out = 1'b0;
  logic       ser_clk_in;
  logic       pad_in = 1'b0;
  logic       pad_out, pad_oe, pad_pd_en;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_sclk_pin u_dut (.*);

  // Vector: [10]se [9]ms [8]sclk [7]pad [6]dir [5]data [4]inh | [3]oe [2]out [1]pd [0]cin
  localparam logic [10:0] VEC [8] = '{
    11'b0_0_0_1_0_0_0_0_0_1_0,
    11'b0_0_0_0_0_1_1_0_1_0_0,
    11'b0_0_1_0_1_1_0_1_1_0_0,
    11'b0_1_1_1_1_0_1_1_0_0_0,
    11'b1_1_1_0_0_0_0_1_1_0_0,
    11'b1_1_0_1_1_1_1_1_0_0_0,
    11'b1_0_0_1_0_0_0_0_0_0_1,
    11'b1_0_1_0_1_1_0_0_1_0_0
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic r;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 oe", pad_oe, 1'b0);
    check("R1 pd", pad_pd_en, 1'b1);
    check("R1 out", pad_out, 1'b0);
    rd_reg(2'd0, r); check("R1 dir", r, 1'b0);
    rd_reg(2'd2, r); check("R1 inh", r, 1'b0);
    pad_in = 1'b1; idle(3); rd_reg(2'd1, r);  // data latch is 0 after reset
    wr_reg(2'd0, 1'b1); rd_reg(2'd1, r); check("R1 data", r, 1'b0);
    wr_reg(2'd0, 1'b0);

    // Table walk: R2 R3 R4 R8 R9 and read path R6 R7
    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      v = VEC[i];
      ser_en = 1'b0;
      wr_reg(2'd0, v[6]); wr_reg(2'd1, v[5]); wr_reg(2'd2, v[4]);
      ser_master = v[9]; ser_clk_out = v[8]; pad_in = v[7]; ser_en = v[10];
      idle(3);
      check("R2/R3/R8/R9 oe", pad_oe, v[3]);
      check("R2/R9 out", pad_out, v[2]);
      check("R4/R8 pd", pad_pd_en, v[1]);
      check("R3 cin", ser_clk_in, v[0]);
      rd_reg(2'd1, r);
      check("R6/R7 data read", r, v[6] ? v[5] : v[7]);
    end

    // R3 slave clock passes combinationally
    ser_en = 1'b1; ser_master = 1'b0; wr_reg(2'd0, 1'b0);
    pad_in = 1'b0; #0.5; check("R3 cin low", ser_clk_in, 1'b0);
    pad_in = 1'b1; #0.5; check("R3 cin high", ser_clk_in, 1'b1);

    // R6 synchronizer latency, while serial owns the pin
    pad_in = 1'b0; idle(3);
    pad_in = 1'b1; idle(1);
    rd_reg(2'd1, r); check("R6 after one edge", r, 1'b0);
    idle(1);
    rd_reg(2'd1, r); check("R6 after two edges", r, 1'b1);

    // R5 writes under serial ownership leave pad untouched
    ser_master = 1'b1; ser_clk_out = 1'b1;
    wr_reg(2'd0, 1'b0); wr_reg(2'd1, 1'b0); wr_reg(2'd2, 1'b1);
    check("R5 oe", pad_oe, 1'b1);
    check("R5 out", pad_out, 1'b1);
    check("R5 pd", pad_pd_en, 1'b0);
    wr_reg(2'd0, 1'b1); wr_reg(2'd1, 1'b1);
    ser_clk_out = 1'b0; #0.5;
    check("R5 out sclk", pad_out, 1'b0);
    rd_reg(2'd0, r); check("R5 dir readback", r, 1'b1);
    rd_reg(2'd2, r); check("R5 inh readback", r, 1'b1);
    rd_reg(2'd1, r); check("R5/R7 data readback", r, 1'b1);

    // R10 release: stored values take over immediately
    wr_reg(2'd0, 1'b0);
    ser_en = 1'b0; #0.5;
    check("R10 oe", pad_oe, 1'b0);
    check("R10 pd inhibited", pad_pd_en, 1'b0);
    wr_reg(2'd2, 1'b0); #0.5;
    check("R8 pd restored", pad_pd_en, 1'b1);

    // R11 reserved address
    wr_reg(2'd3, 1'b1);
    rd_reg(2'd3, r); check("R11 rsvd reads 0", r, 1'b0);
    rd_reg(2'd0, r); check("R11 dir untouched", r, 1'b0);
    rd_reg(2'd2, r); check("R11 inh untouched", r, 1'b0);
    check("R11 oe untouched", pad_oe, 1'b0);

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule